// File: doc/BRIEF.md
# Cascadable Fall-Through Shift FIFO

This block is a first-in first-out buffer built as a column of word stages rather than a RAM with pointers. Every stage holds one word and a flag that says whether it is occupied. A word accepted at the input stage moves one stage per clock toward the output while the stage ahead of it is free. When the output word is taken, the vacated slot climbs back toward the input, also one stage per clock. The default size is 64 words of 4 bits, and everything runs in a single clock domain.

The interface is a strobe-and-ready pair on each side. `shift_in` loads `din` when `in_ready` is high. `shift_out` removes the output word when `out_ready` is high. An output enable releases the data outputs to high impedance. The flags are arranged so that two instances can be chained with plain wires to make a buffer of twice the depth: the upstream `out_ready` feeds the downstream `shift_in`, the upstream `dout` feeds the downstream `din`, and the downstream `in_ready` feeds the upstream `shift_out`. In a chain the handshake looks like a pulse on each side, one per word moved.

Top module: `fts_fifo`

## Requirements
- R1: While the active-high synchronous `rst` is high at a clock edge, every stored word is discarded. After that edge `in_ready` is 1 and `out_ready` is 0.
- R2: `din` is stored only on a clock edge where `shift_in` and `in_ready` are both 1. A `shift_in` while `in_ready` is 0 stores nothing.
- R3: A word accepted into an empty instance raises `out_ready` DEPTH-1 clock edges after the accepting edge (63 for the default depth). `out_ready` is 0 whenever the instance is empty.
- R4: A clock edge with `shift_out` and `out_ready` both 1 removes the output word, and `out_ready` is 0 for at least the following cycle. With `shift_out` held at 1, `out_ready` is therefore a one-cycle pulse per word.
- R5: A `shift_out` while `out_ready` is 0 removes nothing.
- R6: Words leave in the order they were accepted, with none lost and none repeated. While `out_ready` is 1 and `shift_out` is 0, the output word stays stable.
- R7: Once DEPTH words are stored, `in_ready` is 0.
- R8: After a read from a full instance, `in_ready` rises DEPTH-1 clock edges after the reading edge (63 for the default depth).
- R9: With `oe` at 1, `dout` carries the output word whenever `out_ready` is 1. With `oe` at 0, `dout` is high impedance. Both ready flags are always driven.
- R10: Two instances wired directly as described form a 2*DEPTH-word buffer, and each transfer between them moves exactly one word. A single word written into the empty pair reaches the far output after 2*DEPTH-1 edges (127). After one read from the full pair, the near `in_ready` rises after 2*DEPTH-1 edges (127).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high; empties all stages |
| shift_in | input | 1 | Load strobe for `din` |
| shift_out | input | 1 | Removal strobe for the output word |
| din | input | WIDTH | Word to be stored |
| oe | input | 1 | Output enable for `dout` |
| in_ready | output | 1 | Input stage is free |
| out_ready | output | 1 | Output stage holds a word |
| dout | output | WIDTH | Output word, high impedance while `oe` is 0 |

## Verification
The assertions follow the occupancy on every cycle. The stored-word count must rise by one for an accepted load, fall by one for an accepted removal, and stay put otherwise. They also check that a full instance refuses input, that an empty one shows no output, that a removal drops `out_ready` for a cycle, and that a waiting output word does not change. Some behaviour can only be shown by the bench's scenarios on a chained pair: the exact fall-through and bubble-up latencies, the capacity of the pair, and the order of words through long mixed load and removal traffic, which is compared against a queue.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int unsigned FTS_DEPTH_DEF = 64;
    localparam int unsigned FTS_WIDTH_DEF = 4;

    // What a single stage does at the next clock edge.
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOAD = 2'd1,
        ST_DROP = 2'd2
    } stage_act_e;

    // An empty stage takes an offered word. A full stage hands its word
    // on when the consumer ahead of it accepts. The two cannot coincide.
    function automatic stage_act_e stage_action(input logic occupied,
                                                input logic offer,
                                                input logic accept);
        if (!occupied && offer) begin
            return ST_LOAD;
        end else if (occupied && accept) begin
            return ST_DROP;
        end
        return ST_HOLD;
    endfunction

endpackage

// File: rtl/fts_stage.sv
module fts_stage
    import fts_pkg::*;
#(
    parameter int unsigned WIDTH = FTS_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             offer,
    input  logic             accept,
    input  logic [WIDTH-1:0] d_in,
    output logic             full,
    output logic [WIDTH-1:0] d_out
);

    stage_act_e act;

    assign act = stage_action(full, offer, accept);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
        end else begin
            case (act)
                ST_LOAD: full <= 1'b1;
                ST_DROP: full <= 1'b0;
                default: full <= full;
            endcase
        end
    end

    // Data needs no reset: it is qualified by the occupancy flag.
    always_ff @(posedge clk) begin
        if (act == ST_LOAD) begin
            d_out <= d_in;
        end
    end

endmodule

// File: rtl/fts_chain.sv
module fts_chain
    import fts_pkg::*;
#(
    parameter int unsigned DEPTH = FTS_DEPTH_DEF,
    parameter int unsigned WIDTH = FTS_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [DEPTH-1:0] full_vec,
    output logic [WIDTH-1:0] head_word
);

    logic [WIDTH-1:0] word_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_st
        logic             offer_w;
        logic             accept_w;
        logic [WIDTH-1:0] src_w;

        if (i == 0) begin : g_entry
            assign offer_w = push;
            assign src_w   = din;
        end else begin : g_inner
            assign offer_w = full_vec[i-1];
            assign src_w   = word_q[i-1];
        end

        if (i == DEPTH - 1) begin : g_exit
            assign accept_w = pop;
        end else begin : g_flow
            assign accept_w = !full_vec[i+1];
        end

        fts_stage #(.WIDTH(WIDTH)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .offer  (offer_w),
            .accept (accept_w),
            .d_in   (src_w),
            .full   (full_vec[i]),
            .d_out  (word_q[i])
        );
    end

    assign head_word = word_q[DEPTH-1];

endmodule

// File: rtl/fts_flags.sv
module fts_flags
    import fts_pkg::*;
#(
    parameter int unsigned DEPTH = FTS_DEPTH_DEF
) (
    input  logic [DEPTH-1:0] full_vec,
    input  logic             shift_in,
    input  logic             shift_out,
    output logic             in_ready,
    output logic             out_ready,
    output logic             push,
    output logic             pop
);

    assign in_ready  = !full_vec[0];
    assign out_ready = full_vec[DEPTH-1];
    assign push      = shift_in  && in_ready;
    assign pop       = shift_out && out_ready;

endmodule

// File: rtl/fts_outbuf.sv
module fts_outbuf
    import fts_pkg::*;
#(
    parameter int unsigned WIDTH = FTS_WIDTH_DEF
) (
    input  logic             oe,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] bus
);

    assign bus = oe ? word : {WIDTH{1'bz}};

endmodule

// File: rtl/fts_fifo.sv
module fts_fifo
    import fts_pkg::*;
#(
    parameter int unsigned DEPTH = FTS_DEPTH_DEF,
    parameter int unsigned WIDTH = FTS_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    input  logic             oe,
    output logic             in_ready,
    output logic             out_ready,
    output logic [WIDTH-1:0] dout
);

    logic [DEPTH-1:0] full_vec;
    logic [WIDTH-1:0] head_word;
    logic             push;
    logic             pop;

    fts_flags #(.DEPTH(DEPTH)) u_flags (
        .full_vec  (full_vec),
        .shift_in  (shift_in),
        .shift_out (shift_out),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .push      (push),
        .pop       (pop)
    );

    fts_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .din       (din),
        .full_vec  (full_vec),
        .head_word (head_word)
    );

    fts_outbuf #(.WIDTH(WIDTH)) u_outbuf (
        .oe   (oe),
        .word (head_word),
        .bus  (dout)
    );

endmodule

// File: rtl/fts_fifo_chk.sv
module fts_fifo_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_in,
    input logic             shift_out,
    input logic             in_ready,
    input logic             out_ready,
    input logic [DEPTH-1:0] full_vec,
    input logic [WIDTH-1:0] head_word
);

    int   occ;
    logic acc_in;
    logic acc_out;

    always_comb occ = $countones(full_vec);
    assign acc_in  = shift_in && in_ready;
    assign acc_out = shift_out && out_ready;

    AST_OCC_RISE: assert property (@(posedge clk) disable iff (rst)
        (acc_in && !acc_out) |=> (occ == $past(occ) + 1)); // R2

    AST_OCC_FALL: assert property (@(posedge clk) disable iff (rst)
        (!acc_in && acc_out) |=> (occ == $past(occ) - 1)); // R4

    AST_OCC_STEADY: assert property (@(posedge clk) disable iff (rst)
        (acc_in == acc_out) |=> $stable(occ)); // R5

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (occ == DEPTH) |-> !in_ready); // R7

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (occ == 0) |-> !out_ready); // R3

    AST_POP_GAP: assert property (@(posedge clk) disable iff (rst)
        acc_out |=> !out_ready); // R4

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !shift_out) |=> (out_ready && $stable(head_word))); // R6

endmodule

bind fts_fifo fts_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .full_vec  (full_vec),
    .head_word (head_word)
);

// File: tb/sim_fts_fifo.sv
module sim_fts_fifo;

    localparam int CLK_NS = 10;
    localparam int DEPTH  = 64;
    localparam int WIDTH  = 4;
    localparam int TOTAL  = 2 * DEPTH;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             si = 1'b0;
    logic             so_b = 1'b0;
    logic             oe_b = 1'b1;
    logic [WIDTH-1:0] din_a = '0;

    wire              a_ir, a_or, b_ir, b_or;
    wire  [WIDTH-1:0] a_q, b_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit last_pop = 0;
    logic [WIDTH-1:0] ref_q [$];

    always #(CLK_NS / 2) clk = ~clk;

    // Upstream instance
    fts_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst(rst), .shift_in(si), .shift_out(b_ir), .din(din_a),
        .oe(1'b1), .in_ready(a_ir), .out_ready(a_or), .dout(a_q)
    );

    // Downstream instance, wired straight to the upstream one (R10)
    fts_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u1 (
        .clk(clk), .rst(rst), .shift_in(a_or), .shift_out(so_b), .din(a_q),
        .oe(oe_b), .in_ready(b_ir), .out_ready(b_or), .dout(b_q)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Behavioural reference: a queue updated on every clock edge.
    always @(posedge clk) begin
        if (rst) begin
            ref_q.delete();
            last_pop = 0;
        end else begin
            if (ref_q.size() == TOTAL) check("R7 in_ready while pair full", int'(a_ir), 0);
            if (ref_q.size() == 0) check("R5 out_ready while empty", int'(b_or), 0);
            if (last_pop && so_b) check("R4 out_ready pulse gap", int'(b_or), 0);
            if (so_b && b_or) begin
                if (ref_q.size() == 0) begin
                    check("R6 removal from empty model", 1, 0);
                end else begin
                    if (oe_b) check("R6 output order", int'(b_q), int'(ref_q[0]));
                    void'(ref_q.pop_front());
                end
            end
            if (si && a_ir) ref_q.push_back(din_a); // R2
            last_pop = so_b && b_or;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        int first_b;
        logic [15:0] lfsr;

        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        check("R1 in_ready after reset", int'(a_ir), 1);
        check("R1 out_ready after reset", int'(b_or), 0);
        check("R1 upstream out_ready after reset", int'(a_or), 0);

        // R3 / R10 fall-through latency of one word
        si = 1'b1; din_a = 4'hA;
        step();
        si = 1'b0;
        cnt = 0;
        while (!a_or && cnt < 400) begin step(); cnt++; end
        check("R3 single instance fall-through", cnt, DEPTH - 1);
        step(); cnt++;
        check("R10 transfer leaves upstream empty", int'(a_or), 0);
        while (!b_or && cnt < 400) begin step(); cnt++; end
        check("R10 pair fall-through", cnt, TOTAL - 1);
        check("R9 output word with oe high", int'(b_q), 'hA);

        // R4 removal
        so_b = 1'b1;
        step();
        check("R4 out_ready after removal", int'(b_or), 0);

        // R5 removal strobe with nothing stored
        repeat (20) step();
        check("R5 empty stays empty", int'(b_or), 0);
        so_b = 1'b0;
        si = 1'b1; din_a = 4'h3;
        step();
        si = 1'b0;
        cnt = 0;
        while (!b_or && cnt < 400) begin step(); cnt++; end
        check("R5 later word still delivered", int'(b_q), 3);
        check("R9 flag and word together", int'(b_or), 1);
        so_b = 1'b1; step(); so_b = 1'b0;

        // R2 / R7 / R10 fill with shift_in held; refused strobes carry other data
        si = 1'b1;
        for (int i = 0; i < 700; i++) begin
            din_a = 4'(i);
            step();
        end
        si = 1'b0;
        check("R10 pair capacity", ref_q.size(), TOTAL);
        check("R7 upstream in_ready when full", int'(a_ir), 0);
        check("R7 downstream in_ready when full", int'(b_ir), 0);
        check("R2 held strobe adds nothing", ref_q.size(), TOTAL);

        // R8 / R10 bubble-up after one read from the full pair
        so_b = 1'b1; step(); so_b = 1'b0;
        cnt = 0; first_b = -1;
        while (!a_ir && cnt < 400) begin
            step(); cnt++;
            if (b_ir && first_b < 0) first_b = cnt;
        end
        check("R8 single instance bubble-up", first_b, DEPTH - 1);
        check("R10 pair bubble-up", cnt, TOTAL - 1);

        // R6 drain with shift_out held
        so_b = 1'b1;
        repeat (400) step();
        check("R6 drained model", ref_q.size(), 0);
        check("R6 nothing left at output", int'(b_or), 0);

        // R6 / R2 / R5 mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            si    = lfsr[0];
            so_b  = lfsr[3] & lfsr[5];
            din_a = lfsr[11:8];
            step();
        end
        si = 1'b0; so_b = 1'b1;
        repeat (600) step();
        check("R6 mixed traffic drained", ref_q.size(), 0);
        so_b = 1'b0;

        // R1 reset with words in flight
        si = 1'b1;
        repeat (300) begin din_a = din_a + 4'd1; step(); end
        si = 1'b0;
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 in_ready after mid reset", int'(a_ir), 1);
        check("R1 out_ready after mid reset", int'(b_or), 0);
        check("R1 upstream out_ready after mid reset", int'(a_or), 0);
        so_b = 1'b1;
        repeat (200) step();
        check("R1 discarded words never appear", int'(b_or), 0);
        so_b = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule